// File: doc/BRIEF.md
# Reloading Down-Counter Timer Unit with Free-Running Up-Counter

The block is a small timer unit on a word-addressed register bus. It holds three reloadable down-counters: two narrow ones (16 bits by default) and one wide one (32 bits). Each is advanced by one of two tick-enable inputs, a slow tick or a fast tick, chosen per counter. A reloadable counter either reloads from its load register when it passes zero (periodic mode) or wraps to all ones (wrap mode). In both modes passing zero raises a latched interrupt that holds until software writes the counter's clear register. Writing a load value of N-1 gives one interrupt every N selected ticks.

Beside them sits a 40-bit up-counter driven by the fast tick. It never interrupts. It is started and stopped through one bit of its high-word register, and its low 32 bits are read from a separate register. Software typically uses one narrow counter as the periodic system tick and reads the free-running counter to measure time between those ticks.

Each counter owns a 32-byte slot, and the slot index is bus address bits [7:5]. Slots 0 and 1 are the narrow counters, slot 2 is the wide counter, and slot 3 is the free-running counter. Bits [4:2] select a register inside the slot.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every load, value and control register of the three reloading counters reads zero, no interrupt is asserted, and the free-running counter reads zero with its enable bit clear.
- R2: Writing the load register (slot offset 0x0) always updates the stored reload value. It also copies the value into the value register (offset 0x4) when the counter is disabled. While the counter is enabled, the value register is left unchanged.
- R3: Control register (offset 0x8) bit 7 enables counting and bit 3 selects the tick: 1 selects tick_slow and 0 selects tick_fast. An enabled counter decrements by one on each cycle in which its selected tick is high. A disabled counter, or a cycle without the selected tick, leaves the value unchanged.
- R4: With control bit 6 set (periodic mode), a selected tick while the value is zero reloads the value from the load register. A load of N-1 therefore produces one underflow every N selected ticks.
- R5: With control bit 6 clear (wrap mode), a selected tick while the value is zero sets the value to all ones of that counter's width (0xFFFF for a narrow counter, 0xFFFFFFFF for the wide one).
- R6: An underflow sets that counter's irq_o bit on the next clock edge. The bit stays set through any further underflows until a write of any data to the clear register (offset 0xC), which drops it on the next edge. The clear register reads zero.
- R7: If a clear write and an underflow happen on the same edge, the interrupt bit stays set.
- R8: The narrow counters keep only the low 16 bits of a load write and read zeros above bit 15. The wide counter keeps and returns all 32 bits.
- R9: The free-running counter resets to zero and counts up by one on each tick_fast while enabled. Writing its high register (offset 0x64) with bit 8 set enables it. Writing it with bit 8 clear disables it and clears the count. The low register (0x60) reads count bits [31:0]. The high register reads count bits [39:32] in bits [7:0] and the enable in bit 8.
- R10: The control register reads back bits 7, 6 and 3 as last written, and all its other bits read zero.
- R11: Writes to read-only registers (value, free-running low), to unused offsets or slots, and to addresses with bits [1:0] non-zero change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_slow | input | 1 | Slow tick enable, one clock wide per tick |
| tick_fast | input | 1 | Fast tick enable, one clock wide per tick |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 3 | Latched underflow interrupts, one per reloading counter |

## Verification
The hardest situations to reach are the ones where interrupt events collide. The first is a clear write landing on the same edge as a new underflow. The second is a counter passing zero a second time while its interrupt is still pending. A directed sequence counts the value register down to zero and then issues the tick and the clear write in one cycle. It also lets a counter underflow twice without a clear before acknowledging it. The random phase uses load values that are mostly below 24 and mixes ticks, mode changes and clears, so that underflows, reloads mid-count and collisions occur many times across all three counters.

// File: rtl/tmr_pkg.sv
`timescale 1ns/10ps
package tmr_pkg;
   // address layout: 32-byte slot per counter, word registers inside
   localparam int SLOT_LG = 5;
   localparam int WORD_LG = 2;
   localparam int REGI_W  = SLOT_LG - WORD_LG;
   typedef logic [REGI_W-1:0] regi_t;

   localparam regi_t REG_LOAD  = regi_t'(0);
   localparam regi_t REG_VALUE = regi_t'(1);
   localparam regi_t REG_CTRL  = regi_t'(2);
   localparam regi_t REG_CLEAR = regi_t'(3);
   localparam regi_t FREE_LO   = regi_t'(0);
   localparam regi_t FREE_HI   = regi_t'(1);

   // control bit positions
   localparam int CTRL_EN_BIT   = 7;
   localparam int CTRL_PER_BIT  = 6;
   localparam int CTRL_SLOW_BIT = 3;
   localparam int FREE_EN_BIT   = 8;

   typedef struct packed {
      logic en;
      logic per;
      logic slow;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_bus_dec.sv
`timescale 1ns/10ps
module tmr_bus_dec
   import tmr_pkg::*;
#(
   parameter int AW      = 8,
   parameter int NUM_TMR = 3,
   localparam int SLOT_W = AW - SLOT_LG
) (
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   output logic [NUM_TMR-1:0] ld_wr,
   output logic [NUM_TMR-1:0] ctrl_wr,
   output logic [NUM_TMR-1:0] clr_wr,
   output logic               fhi_wr,
   output logic [SLOT_W-1:0]  slot,
   output regi_t              regi,
   output logic               aligned
);
   if (AW <= SLOT_LG) begin : g_bad_aw
      $error("tmr_bus_dec: address too narrow for one slot");
   end
   if (NUM_TMR + 1 > (1 << SLOT_W)) begin : g_bad_slots
      $error("tmr_bus_dec: not enough slots for all counters");
   end

   logic wr_en;

   assign slot    = bus_addr[AW-1:SLOT_LG];
   assign regi    = bus_addr[SLOT_LG-1:WORD_LG];
   assign aligned = (bus_addr[WORD_LG-1:0] == '0);
   assign wr_en   = bus_sel && bus_wr && aligned;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_slot
      logic here;
      assign here       = wr_en && (slot == SLOT_W'(i));
      assign ld_wr[i]   = here && (regi == REG_LOAD);
      assign ctrl_wr[i] = here && (regi == REG_CTRL);
      assign clr_wr[i]  = here && (regi == REG_CLEAR);
   end

   assign fhi_wr = wr_en && (slot == SLOT_W'(NUM_TMR)) && (regi == FREE_HI);
endmodule

// File: rtl/tmr_reload_ctr.sv
`timescale 1ns/10ps
module tmr_reload_ctr
   import tmr_pkg::*;
#(
   parameter int W  = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_slow,
   input  logic          tick_fast,
   input  logic          ld_wr,
   input  logic          ctrl_wr,
   input  logic          clr_wr,
   input  logic [W-1:0]  ld_data,
   input  logic          ctl_en_d,
   input  logic          ctl_per_d,
   input  logic          ctl_slow_d,
   output logic [DW-1:0] load_rd,
   output logic [DW-1:0] val_rd,
   output logic [DW-1:0] ctrl_rd,
   output logic          irq_o,
   output logic          uf_o,
   output logic          en_o,
   output logic          per_o
);
   if (W < 2 || W > DW) begin : g_bad_w
      $error("tmr_reload_ctr: counter width out of range");
   end

   logic [W-1:0] load_q;
   logic [W-1:0] val_q;
   logic [W-1:0] val_nxt;
   tmr_ctrl_t    ctl_q;
   logic         irq_q;
   logic         step;
   logic         uf;

   assign step = ctl_q.en && (ctl_q.slow ? tick_slow : tick_fast);
   assign uf   = step && (val_q == '0);

   always_comb begin
      if (val_q == '0) val_nxt = ctl_q.per ? load_q : '1;
      else             val_nxt = val_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         val_q  <= '0;
         ctl_q  <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (ld_wr) load_q <= ld_data;
         if (ctrl_wr) begin
            ctl_q.en   <= ctl_en_d;
            ctl_q.per  <= ctl_per_d;
            ctl_q.slow <= ctl_slow_d;
         end
         if (ld_wr && !ctl_q.en) val_q <= ld_data;
         else if (step)          val_q <= val_nxt;
         if (uf)          irq_q <= 1'b1;
         else if (clr_wr) irq_q <= 1'b0;
      end
   end

   // readback width adaptation
   if (W < DW) begin : g_pad
      assign load_rd = {{(DW-W){1'b0}}, load_q};
      assign val_rd  = {{(DW-W){1'b0}}, val_q};
   end else begin : g_full
      assign load_rd = load_q;
      assign val_rd  = val_q;
   end

   always_comb begin
      ctrl_rd                = '0;
      ctrl_rd[CTRL_EN_BIT]   = ctl_q.en;
      ctrl_rd[CTRL_PER_BIT]  = ctl_q.per;
      ctrl_rd[CTRL_SLOW_BIT] = ctl_q.slow;
   end

   assign irq_o = irq_q;
   assign uf_o  = uf;
   assign en_o  = ctl_q.en;
   assign per_o = ctl_q.per;
endmodule

// File: rtl/tmr_free_ctr.sv
`timescale 1ns/10ps
module tmr_free_ctr
   import tmr_pkg::*;
#(
   parameter int CW = 40,
   parameter int DW = 32,
   localparam int HI_W = CW - DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          hi_wr,
   input  logic          en_d,
   output logic [DW-1:0] lo_rd,
   output logic [DW-1:0] hi_rd,
   output logic          en_o,
   output logic [CW-1:0] cnt_o
);
   if (HI_W < 1 || HI_W > FREE_EN_BIT) begin : g_bad_cw
      $error("tmr_free_ctr: upper count bits must sit below the enable bit");
   end

   logic [CW-1:0] cnt_q;
   logic          en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (hi_wr && !en_d) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (en_q && tick) cnt_q <= cnt_q + 1'b1;
         if (hi_wr)        en_q  <= 1'b1;
      end
   end

   assign lo_rd = cnt_q[DW-1:0];

   always_comb begin
      hi_rd              = '0;
      hi_rd[HI_W-1:0]    = cnt_q[CW-1:DW];
      hi_rd[FREE_EN_BIT] = en_q;
   end

   assign en_o  = en_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/10ps
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int SHORT_W   = 16,
   parameter int LONG_W    = 32,
   parameter int NUM_SHORT = 2,
   parameter int NUM_LONG  = 1,
   parameter int FREE_W    = 40,
   parameter int AW        = 8,
   parameter int DW        = 32,
   localparam int NUM_TMR  = NUM_SHORT + NUM_LONG,
   localparam int SLOT_W   = AW - SLOT_LG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_slow,
   input  logic               tick_fast,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   output logic [NUM_TMR-1:0] irq_o
);
   if (LONG_W > DW || SHORT_W > LONG_W) begin : g_bad_widths
      $error("tmr_unit: counter widths must satisfy SHORT_W <= LONG_W <= DW");
   end
   if (DW <= FREE_EN_BIT) begin : g_bad_dw
      $error("tmr_unit: data bus too narrow for control fields");
   end

   logic [NUM_TMR-1:0]          ld_wr, ctrl_wr, clr_wr;
   logic [NUM_TMR-1:0]          uf, en, per;
   logic                        fhi_wr;
   logic [SLOT_W-1:0]           slot;
   regi_t                       regi;
   logic                        aligned;
   logic [NUM_TMR-1:0][DW-1:0]  load_rd, val_rd, ctrl_rd;
   logic [DW-1:0]               free_lo, free_hi;
   logic                        free_en;
   logic [FREE_W-1:0]           free_cnt;

   tmr_bus_dec #(.AW(AW), .NUM_TMR(NUM_TMR)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .ld_wr   (ld_wr),
      .ctrl_wr (ctrl_wr),
      .clr_wr  (clr_wr),
      .fhi_wr  (fhi_wr),
      .slot    (slot),
      .regi    (regi),
      .aligned (aligned)
   );

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      localparam int TW = (i < NUM_SHORT) ? SHORT_W : LONG_W;
      tmr_reload_ctr #(.W(TW), .DW(DW)) u_ctr (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_slow (tick_slow),
         .tick_fast (tick_fast),
         .ld_wr     (ld_wr[i]),
         .ctrl_wr   (ctrl_wr[i]),
         .clr_wr    (clr_wr[i]),
         .ld_data   (bus_wdata[TW-1:0]),
         .ctl_en_d  (bus_wdata[CTRL_EN_BIT]),
         .ctl_per_d (bus_wdata[CTRL_PER_BIT]),
         .ctl_slow_d(bus_wdata[CTRL_SLOW_BIT]),
         .load_rd   (load_rd[i]),
         .val_rd    (val_rd[i]),
         .ctrl_rd   (ctrl_rd[i]),
         .irq_o     (irq_o[i]),
         .uf_o      (uf[i]),
         .en_o      (en[i]),
         .per_o     (per[i])
      );
   end

   tmr_free_ctr #(.CW(FREE_W), .DW(DW)) u_free (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_fast),
      .hi_wr(fhi_wr),
      .en_d (bus_wdata[FREE_EN_BIT]),
      .lo_rd(free_lo),
      .hi_rd(free_hi),
      .en_o (free_en),
      .cnt_o(free_cnt)
   );

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         for (int i = 0; i < NUM_TMR; i++) begin
            if (slot == SLOT_W'(i)) begin
               case (regi)
                  REG_LOAD:  bus_rdata = load_rd[i];
                  REG_VALUE: bus_rdata = val_rd[i];
                  REG_CTRL:  bus_rdata = ctrl_rd[i];
                  default:   bus_rdata = '0;
               endcase
            end
         end
         if (slot == SLOT_W'(NUM_TMR)) begin
            if (regi == FREE_LO)      bus_rdata = free_lo;
            else if (regi == FREE_HI) bus_rdata = free_hi;
         end
      end
   end
endmodule

// File: rtl/tmr_unit_chk.sv
`timescale 1ns/10ps
module tmr_unit_chk #(
   parameter int NUM_TMR = 3,
   parameter int DW      = 32,
   parameter int FREE_W  = 40
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_TMR-1:0]         irq_o,
   input logic [NUM_TMR-1:0]         clr_wr,
   input logic [NUM_TMR-1:0]         ld_wr,
   input logic [NUM_TMR-1:0]         uf,
   input logic [NUM_TMR-1:0]         en,
   input logic [NUM_TMR-1:0]         per,
   input logic [NUM_TMR-1:0][DW-1:0] val_rd,
   input logic [NUM_TMR-1:0][DW-1:0] load_rd,
   input logic                       free_en,
   input logic [FREE_W-1:0]          free_cnt
);
   for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
      assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[i] && !clr_wr[i] |=> irq_o[i]);
      assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_o[i] |=> (irq_o[i] == $past(uf[i])));
      assert_uf_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         uf[i] |=> irq_o[i]);
      assert_clr_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
         clr_wr[i] && !uf[i] |=> !irq_o[i]);
      assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
         uf[i] && per[i] |=> (val_rd[i] == $past(load_rd[i])));
      assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !en[i] && !ld_wr[i] |=> $stable(val_rd[i]));
   end

   assert_free_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      free_en |=> (free_cnt == $past(free_cnt) ||
                   free_cnt == $past(free_cnt) + FREE_W'(1) ||
                   free_cnt == '0));
   assert_free_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !free_en |-> (free_cnt == '0));
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_TMR(NUM_TMR), .DW(DW), .FREE_W(FREE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_o   (irq_o),
   .clr_wr  (clr_wr),
   .ld_wr   (ld_wr),
   .uf      (uf),
   .en      (en),
   .per     (per),
   .val_rd  (val_rd),
   .load_rd (load_rd),
   .free_en (free_en),
   .free_cnt(free_cnt)
);

// File: tb/tmr_unit_tb_top.sv
`timescale 1ns/10ps
module tmr_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_slow = 1'b0, tick_fast = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq_o;

   int n_chk = 0;
   int n_err = 0;

   // bench model, built from the requirements
   logic [31:0] m_load [3];
   logic [31:0] m_val  [3];
   bit          m_en [3], m_per [3], m_slow [3], m_irq [3];
   bit          m_fen;
   logic [39:0] m_fcnt;

   logic [31:0] ctl_pick [6] = '{32'h48, 32'hC8, 32'h88, 32'h80, 32'hC0, 32'h00};

   always #2.5 clk = ~clk;

   tmr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [31:0] wmask(int i);
      return (i < 2) ? 32'h0000FFFF : 32'hFFFFFFFF;
   endfunction

   function automatic logic [31:0] ctl_word(int i);
      return {24'b0, m_en[i], m_per[i], 2'b0, m_slow[i], 3'b0};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit ts, input bit tf, input bit wr,
                       input logic [7:0] a, input logic [31:0] d);
      logic [31:0] n_load [3];
      logic [31:0] n_val [3];
      bit          n_en [3], n_per [3], n_slow [3], n_irq [3];
      bit          n_fen;
      logic [39:0] n_fcnt;
      int          idx, r;
      bit          ok, tk, ufl, hit, hhi;
      @(negedge clk);
      tick_slow = ts; tick_fast = tf;
      bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
      idx = int'(a[7:5]); r = int'(a[4:2]); ok = wr && (a[1:0] == 2'b00);
      for (int i = 0; i < 3; i++) begin
         n_load[i] = m_load[i]; n_val[i] = m_val[i];
         n_en[i] = m_en[i]; n_per[i] = m_per[i]; n_slow[i] = m_slow[i]; n_irq[i] = m_irq[i];
         tk  = m_slow[i] ? ts : tf;
         ufl = m_en[i] && tk && (m_val[i] == 0);
         hit = ok && (idx == i);
         if (hit && r == 0) n_load[i] = d & wmask(i);
         if (hit && r == 2) begin n_en[i] = d[7]; n_per[i] = d[6]; n_slow[i] = d[3]; end
         if (hit && r == 0 && !m_en[i]) n_val[i] = d & wmask(i);
         else if (m_en[i] && tk)
            n_val[i] = (m_val[i] == 0) ? (m_per[i] ? m_load[i] : wmask(i)) : m_val[i] - 1;
         if (ufl) n_irq[i] = 1'b1;
         else if (hit && r == 3) n_irq[i] = 1'b0;
      end
      hhi = ok && idx == 3 && r == 1;
      n_fen = m_fen; n_fcnt = m_fcnt;
      if (hhi && !d[8]) begin n_fen = 1'b0; n_fcnt = '0; end
      else begin
         if (m_fen && tf) n_fcnt = m_fcnt + 40'd1;
         if (hhi) n_fen = 1'b1;
      end
      @(posedge clk);
      for (int i = 0; i < 3; i++) begin
         m_load[i] = n_load[i]; m_val[i] = n_val[i]; m_en[i] = n_en[i];
         m_per[i] = n_per[i]; m_slow[i] = n_slow[i]; m_irq[i] = n_irq[i];
      end
      m_fen = n_fen; m_fcnt = n_fcnt;
      #1;
      for (int i = 0; i < 3; i++) chk("R6 irq", irq_o[i], m_irq[i]);
   endtask

   task automatic idle_read(input logic [7:0] a);
      @(negedge clk);
      tick_slow = 0; tick_fast = 0; bus_wr = 0; bus_sel = 1; bus_addr = a;
      #0.1;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      idle_read(a);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic check_regs();
      logic [31:0] e;
      @(negedge clk);
      tick_slow = 0; tick_fast = 0; bus_wr = 0; bus_sel = 1;
      for (int i = 0; i < 3; i++) begin
         for (int r = 0; r < 4; r++) begin
            bus_addr = {3'(i), 3'(r), 2'b00};
            #0.1;
            case (r)
               0: begin e = m_load[i]; chk("R2 load", bus_rdata, e); end
               1: begin e = m_val[i];  chk("R4 value", bus_rdata, e); end
               2: begin e = ctl_word(i); chk("R10 ctrl", bus_rdata, e); end
               default: chk("R6 clear reads zero", bus_rdata, 32'h0);
            endcase
         end
      end
      bus_addr = 8'h60; #0.1;
      chk("R9 free low", bus_rdata, m_fcnt[31:0]);
      bus_addr = 8'h64; #0.1;
      chk("R9 free high", bus_rdata, {23'b0, m_fen, m_fcnt[39:32]});
   endtask

   initial begin
      #1000000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 3; i++) begin
         m_load[i] = '0; m_val[i] = '0; m_en[i] = 0; m_per[i] = 0; m_slow[i] = 0; m_irq[i] = 0;
      end
      m_fen = 0; m_fcnt = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      check_regs();
      rd_chk("R1 value0", 8'h04, 32'h0);
      rd_chk("R1 free high", 8'h64, 32'h0);
      chk("R1 irq", irq_o, 3'b000);

      // R2 load while disabled, periodic count on slow tick
      step(0, 0, 1, 8'h00, 32'd4);
      rd_chk("R2 value copy", 8'h04, 32'd4);
      step(0, 0, 1, 8'h08, 32'hC8);
      repeat (4) step(1, 0, 0, 8'h00, 0);
      rd_chk("R4 reached zero", 8'h04, 32'd0);
      chk("R6 no irq before underflow", irq_o[0], 1'b0);
      step(1, 0, 0, 8'h00, 0);
      rd_chk("R4 reload", 8'h04, 32'd4);
      chk("R6 irq set", irq_o[0], 1'b1);
      step(0, 0, 1, 8'h00, 32'd9);
      rd_chk("R2 value kept while enabled", 8'h04, 32'd4);
      rd_chk("R2 load updated", 8'h00, 32'd9);
      step(0, 1, 0, 8'h00, 0);
      rd_chk("R3 fast tick ignored", 8'h04, 32'd4);
      step(1, 0, 0, 8'h00, 0);
      rd_chk("R3 slow tick counts", 8'h04, 32'd3);

      // R6 second underflow with irq pending, then clear
      repeat (4) step(1, 0, 0, 8'h00, 0);
      rd_chk("R4 reload new load", 8'h04, 32'd9);
      chk("R6 irq held", irq_o[0], 1'b1);
      step(0, 0, 1, 8'h0C, 32'hA5);
      chk("R6 cleared", irq_o[0], 1'b0);

      // R7 clear on the underflow edge
      repeat (9) step(1, 0, 0, 8'h00, 0);
      rd_chk("R7 at zero", 8'h04, 32'd0);
      step(1, 0, 1, 8'h0C, 32'h0);
      chk("R7 irq survives clear", irq_o[0], 1'b1);

      // R5 wrap mode on narrow and wide counters
      step(0, 0, 1, 8'h20, 32'd0);
      step(0, 0, 1, 8'h28, 32'h88);
      step(1, 0, 0, 8'h00, 0);
      rd_chk("R5 narrow wrap", 8'h24, 32'h0000FFFF);
      chk("R5 narrow irq", irq_o[1], 1'b1);
      step(0, 0, 1, 8'h40, 32'd0);
      step(0, 0, 1, 8'h48, 32'h88);
      step(1, 0, 0, 8'h00, 0);
      rd_chk("R5 wide wrap", 8'h44, 32'hFFFFFFFF);

      // R8 widths
      step(0, 0, 1, 8'h28, 32'h0);
      step(0, 0, 1, 8'h20, 32'h00012345);
      rd_chk("R8 narrow load", 8'h20, 32'h00002345);
      rd_chk("R8 narrow value", 8'h24, 32'h00002345);
      step(0, 0, 1, 8'h48, 32'h0);
      step(0, 0, 1, 8'h40, 32'hDEADBEEF);
      rd_chk("R8 wide load", 8'h40, 32'hDEADBEEF);

      // R10 control readback
      step(0, 0, 1, 8'h28, 32'hFF);
      rd_chk("R10 ctrl bits", 8'h28, 32'h000000C8);
      step(0, 0, 1, 8'h28, 32'h37);
      rd_chk("R10 other bits zero", 8'h28, 32'h0);

      // R3 fast tick selection
      step(0, 0, 1, 8'h28, 32'h80);
      step(1, 0, 0, 8'h00, 0);
      rd_chk("R3 slow ignored in fast mode", 8'h24, 32'h00002345);
      step(0, 1, 0, 8'h00, 0);
      rd_chk("R3 fast counts", 8'h24, 32'h00002344);
      step(0, 0, 1, 8'h28, 32'h0);

      // R9 free-running counter
      step(0, 0, 1, 8'h64, 32'h100);
      repeat (5) step(0, 1, 0, 8'h00, 0);
      step(1, 0, 0, 8'h00, 0);
      rd_chk("R9 low count", 8'h60, 32'd5);
      rd_chk("R9 high enable", 8'h64, 32'h100);
      step(0, 0, 1, 8'h64, 32'h0);
      rd_chk("R9 disable clears", 8'h60, 32'd0);

      // R11 ignored writes
      step(0, 0, 1, 8'h24, 32'h55);
      rd_chk("R11 value read-only", 8'h24, 32'h00002344);
      step(0, 0, 1, 8'h60, 32'h1234);
      rd_chk("R11 free low read-only", 8'h60, 32'h0);
      step(0, 0, 1, 8'h70, 32'hFFFFFFFF);
      step(0, 0, 1, 8'hE0, 32'hFFFFFFFF);
      step(0, 0, 1, 8'h21, 32'h7);
      rd_chk("R11 misaligned load ignored", 8'h20, 32'h00002345);
      check_regs();

      // random phase
      for (int k = 0; k < 4000; k++) begin
         bit ts, tf, wr;
         int sel, slt, r;
         logic [7:0] a;
         logic [31:0] d;
         ts = ($urandom % 4) == 0;
         tf = ($urandom % 2) == 0;
         wr = ($urandom % 6) == 0;
         sel = $urandom % 16;
         d = $urandom;
         if (sel == 0) a = 8'($urandom);
         else if (sel < 14) begin
            slt = $urandom % 3; r = $urandom % 4;
            a = {3'(slt), 3'(r), 2'b00};
            if (r == 0) d = (($urandom % 8) == 0) ? $urandom : ($urandom % 24);
            else if (r == 2) d = ctl_pick[$urandom % 6];
         end else begin
            r = $urandom % 2;
            a = {3'd3, 3'(r), 2'b00};
            d = (($urandom % 3) == 0) ? 32'h0 : 32'h100;
         end
         step(ts, tf, wr, a, d);
         if ((k % 32) == 31) check_regs();
      end
      check_regs();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule